// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer behind a small register interface. A 32-bit up-counter advances on a slow functional tick, which is presented as a one-cycle enable in the bus clock domain. An optional prescaler sits in front of it. Software restarts the count by writing the service register. Each service write copies the load register into the counter, but only when the written word differs from the previous one, so software alternates a pattern with its complement. If software stops servicing and the counter rolls over from all-ones to zero, the block emits a one-cycle reset pulse and reloads.

The counter can only be started or stopped by an ordered pair of key words written to the key register. Every write to a writable register is posted. It sits in a staging slot with a pending flag until two functional ticks have passed, and only then takes effect. Software polls the pending register before it relies on a write. A read-only revision register identifies the block.

Register addresses: 0 revision, 1 control, 2 counter (read only), 3 load, 4 service, 5 pending, 6 key.

Top module: `keyed_watchdog`

## Requirements
- R1: After a synchronous active-low reset, the counter, load and service registers read 0, the pending register reads 0 and `wdt_rst_o` is low.
- R2: A write to control, load, service or key sets pending bit 0, 2, 3 or 4 respectively in the same edge. The bit clears on the second functional tick that follows, and the staged value takes effect on that edge.
- R3: A key write of 0x0000BBBB followed directly by 0x00004444 (the next key write to take effect) starts the counter.
- R4: A key write of 0x0000AAAA followed directly by 0x00005555 stops the counter.
- R5: Any other key word breaks a pending sequence, and the run state stays as it was.
- R6: A service write whose word differs from the stored service word reloads the counter from the load register. A repeat of the stored word changes nothing.
- R7: Control bit 5 enables the prescaler and bits 4:2 hold a ratio r. With the prescaler on, the running counter advances once every 2^r ticks. With it off, the counter advances once per tick.
- R8: When the running counter steps from 0xFFFFFFFF, it loads the load register and `wdt_rst_o` is high for exactly one clock.
- R9: The revision register returns the REVISION parameter in bits 7:0 and zeros above.
- R10: The counter changes only on a functional tick, and never while stopped unless a service reload occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| func_tick | input | 1 | One-cycle enable for each functional-clock tick |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| wdt_rst_o | output | 1 | One-cycle reset pulse on counter rollover |

## Verification
The assertions assume that `func_tick` is never high on two consecutive clocks. They also assume that software waits for a register's pending bit to clear before writing that register again, and that load and service writes never take effect on the same tick. The stimulus generates a tick every fourth clock and polls the pending register after every write, which keeps all three conditions true. A behavioural reference model in the bench tracks staging slots, key state and prescaler phase. It is compared with the read port and the reset output on every clock.

// File: rtl/wdt_pkg.sv
// Shared constants for the keyed watchdog: register map, key words and
// posted-write slot numbering. Assumes a 3-bit register address.
package wdt_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;
    localparam int NSLOT  = 4;

    localparam logic [ADDR_W-1:0] A_REV  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_LOAD = 3'd3;
    localparam logic [ADDR_W-1:0] A_SVC  = 3'd4;
    localparam logic [ADDR_W-1:0] A_PEND = 3'd5;
    localparam logic [ADDR_W-1:0] A_KEY  = 3'd6;

    localparam int S_CTRL = 0;
    localparam int S_LOAD = 1;
    localparam int S_SVC  = 2;
    localparam int S_KEY  = 3;

    localparam logic [DATA_W-1:0] KEY_GO1   = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_GO2   = 32'h0000_4444;
    localparam logic [DATA_W-1:0] KEY_HALT1 = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_HALT2 = 32'h0000_5555;

    // Register address served by a posted slot.
    function automatic logic [ADDR_W-1:0] slot_addr(input int s);
        case (s)
            S_CTRL:  return A_CTRL;
            S_LOAD:  return A_LOAD;
            S_SVC:   return A_SVC;
            default: return A_KEY;
        endcase
    endfunction

    // Bit position of a slot's flag in the pending register.
    function automatic int slot_pbit(input int s);
        case (s)
            S_CTRL:  return 0;
            S_LOAD:  return 2;
            S_SVC:   return 3;
            default: return 4;
        endcase
    endfunction
endpackage

// File: rtl/wdt_post_slot.sv
// One posted-write slot. It captures a bus write, holds it pending and
// releases it as a one-cycle apply strobe on the second functional tick
// after the write. A fresh write restarts the delay.
// Assumes func_tick is a single-cycle enable.
module wdt_post_slot #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          func_tick,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    output logic          pend,
    output logic          apply,
    output logic [DW-1:0] data
);
    logic seen_one;

    // Apply strobe: second tick of a pending write, unless a new write lands.
    assign apply = pend && func_tick && seen_one && !wr;

    // Capture the write, then count ticks until it takes effect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            seen_one <= 1'b0;
            data     <= '0;
        end else if (wr) begin
            pend     <= 1'b1;
            seen_one <= 1'b0;
            data     <= wdata;
        end else if (pend && func_tick) begin
            if (seen_one) pend <= 1'b0;
            seen_one <= ~seen_one;
        end
    end
endmodule

// File: rtl/wdt_key_seq.sv
// Two-word key checker for the start/stop register. It looks at applied
// key words only. A start or stop pair must be back to back among
// applied key words, and any other word drops a half-entered pair.
module wdt_key_seq
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply,
    input  logic [DATA_W-1:0] word,
    output logic              run
);
    logic arm_go, arm_halt;

    // Track the first key word and switch the run state on the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run      <= 1'b0;
            arm_go   <= 1'b0;
            arm_halt <= 1'b0;
        end else if (apply) begin
            if (arm_go && word == KEY_GO2)     run <= 1'b1;
            if (arm_halt && word == KEY_HALT2) run <= 1'b0;
            arm_go   <= (word == KEY_GO1);
            arm_halt <= (word == KEY_HALT1);
        end
    end
endmodule

// File: rtl/wdt_tick_counter.sv
// Prescaler and up-counter. When running, the counter steps on each
// functional tick, or once every 2^ratio ticks when the prescaler is on.
// Rolling over from all-ones reloads it and raises a one-cycle wrap pulse.
// A service reload takes priority over counting.
module wdt_tick_counter #(
    parameter int CNT_W   = 32,
    parameter int RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               func_tick,
    input  logic               run,
    input  logic               pre_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               ps_clr,
    input  logic               reload,
    input  logic [CNT_W-1:0]   load_val,
    output logic [CNT_W-1:0]   count,
    output logic               wrap
);
    localparam int PS_W = (1 << RATIO_W) - 1;

    logic [PS_W-1:0] ps, lim;
    logic            step, adv;

    assign lim  = (PS_W'(1) << ratio) - PS_W'(1);
    assign step = !pre_en || (ps == lim);
    assign adv  = run && func_tick;

    // Prescaler phase: restarted by reload or a control update.
    always_ff @(posedge clk) begin
        if (!rst_n)                ps <= '0;
        else if (reload || ps_clr) ps <= '0;
        else if (adv)              ps <= step ? '0 : ps + PS_W'(1);
    end

    // Counter with reload priority and rollover detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            wrap  <= 1'b0;
        end else begin
            wrap <= 1'b0;
            if (reload) begin
                count <= load_val;
            end else if (adv && step) begin
                if (&count) begin
                    count <= load_val;
                    wrap  <= 1'b1;
                end else begin
                    count <= count + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/keyed_watchdog.sv
// Top of the keyed watchdog. It holds the posted-write slots, the
// effective control, load and service registers, the key checker, the
// counter and the read mux. Assumes rd_data is registered by the bus side.
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int         CNT_W    = 32,
    parameter int         RATIO_W  = 3,
    parameter logic [7:0] REVISION = 8'h31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              func_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wdt_rst_o
);
    logic [DATA_W-1:0]  stage [NSLOT];
    logic [NSLOT-1:0]   pend_vec, apply_vec;
    logic [DATA_W-1:0]  pend_reg;
    logic               pre_en, run, reload;
    logic [RATIO_W-1:0] ratio;
    logic [CNT_W-1:0]   load_q, count;
    logic [DATA_W-1:0]  svc_q;
    logic               key_apply;
    logic [DATA_W-1:0]  key_word;
    logic               unused_ctrl_bits;

    // One posted slot per writable register.
    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        wdt_post_slot #(.DW(DATA_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .func_tick(func_tick),
            .wr       (wr_en && wr_addr == slot_addr(s)),
            .wdata    (wr_data),
            .pend     (pend_vec[s]),
            .apply    (apply_vec[s]),
            .data     (stage[s])
        );
    end

    // Place each slot's pending flag at its register bit.
    always_comb begin
        pend_reg = '0;
        for (int s = 0; s < NSLOT; s++) pend_reg[slot_pbit(s)] = pend_vec[s];
    end

    assign unused_ctrl_bits = ^{stage[S_CTRL][DATA_W-1:6], stage[S_CTRL][1:0]};
    assign reload    = apply_vec[S_SVC] && (stage[S_SVC] != svc_q);
    assign key_apply = apply_vec[S_KEY];
    assign key_word  = stage[S_KEY];

    // Effective registers, updated when their posted write lands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_en <= 1'b0;
            ratio  <= '0;
            load_q <= '0;
            svc_q  <= '0;
        end else begin
            if (apply_vec[S_CTRL]) begin
                pre_en <= stage[S_CTRL][5];
                ratio  <= stage[S_CTRL][2 +: RATIO_W];
            end
            if (apply_vec[S_LOAD]) load_q <= stage[S_LOAD][CNT_W-1:0];
            if (reload)            svc_q  <= stage[S_SVC];
        end
    end

    wdt_key_seq u_key (
        .clk  (clk),
        .rst_n(rst_n),
        .apply(key_apply),
        .word (key_word),
        .run  (run)
    );

    wdt_tick_counter #(.CNT_W(CNT_W), .RATIO_W(RATIO_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .func_tick(func_tick),
        .run      (run),
        .pre_en   (pre_en),
        .ratio    (ratio),
        .ps_clr   (apply_vec[S_CTRL]),
        .reload   (reload),
        .load_val (load_q),
        .count    (count),
        .wrap     (wdt_rst_o)
    );

    // Read mux over the register map.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_REV:   rd_data[7:0] = REVISION;
            A_CTRL:  begin
                rd_data[5] = pre_en;
                rd_data[2 +: RATIO_W] = ratio;
            end
            A_CNT:   rd_data = DATA_W'(count);
            A_LOAD:  rd_data = DATA_W'(load_q);
            A_SVC:   rd_data = svc_q;
            A_PEND:  rd_data = pend_reg;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/keyed_watchdog_chk.sv
// Assertion checker for keyed_watchdog, attached with bind. Assumes
// func_tick is never high on two consecutive clocks.
module keyed_watchdog_chk
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              func_tick,
    input logic              wr_en,
    input logic [NSLOT-1:0]  pend_vec,
    input logic              run,
    input logic              reload,
    input logic [CNT_W-1:0]  load_q,
    input logic [CNT_W-1:0]  count,
    input logic              key_apply,
    input logic [DATA_W-1:0] key_word,
    input logic              wdt_rst_o
);
    // R2: a pending flag only rises after a bus write.
    a_r2_rise_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_vec & ~$past(pend_vec))) |-> $past(wr_en));
    // R2: a pending flag only clears on a functional tick.
    a_r2_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~pend_vec & $past(pend_vec))) |-> $past(func_tick));
    // R3: the counter starts only on the second start key word.
    a_r3_start_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $past(key_apply && key_word == KEY_GO2));
    // R4: the counter stops only on the second stop key word.
    a_r4_stop_key: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> $past(key_apply && key_word == KEY_HALT2));
    // R6: a reload places the load value in the counter.
    a_r6_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> count == $past(load_q));
    // R8: the reset pulse lasts one clock.
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> !wdt_rst_o);
    // R8: a rollover needs a running counter.
    a_r8_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> $past(run));
    // R10: without a tick the counter holds.
    a_r10_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !func_tick |=> $stable(count));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .func_tick(func_tick),
    .wr_en    (wr_en),
    .pend_vec (pend_vec),
    .run      (run),
    .reload   (reload),
    .load_q   (load_q),
    .count    (count),
    .key_apply(key_apply),
    .key_word (key_word),
    .wdt_rst_o(wdt_rst_o)
);

// File: tb/keyed_watchdog_bench.sv
// Bench for keyed_watchdog: a behavioural reference model compared on
// every clock, plus directed checks for each requirement.
module keyed_watchdog_bench;
    localparam logic [7:0] REV = 8'h5A;
    localparam logic [2:0] AREV = 0, ACTRL = 1, ACNT = 2, ALOAD = 3,
                           ASVC = 4, APEND = 5, AKEY = 6;
    localparam logic [2:0] SA [4] = '{3'd1, 3'd3, 3'd4, 3'd6};

    logic        clk = 0, rst_n = 0, func_tick = 0, wr_en = 0;
    logic [2:0]  wr_addr = 0, rd_addr = 0;
    logic [31:0] wr_data = 0, rd_data;
    logic        wdt_rst_o;
    int          n_chk = 0, n_fail = 0, cyc = 0, tdiv = 0;
    bit          cmp_on = 0;
    int          hi_len = 0, n_pulse = 0;

    keyed_watchdog #(.REVISION(REV)) u_keyed_watchdog (
        .clk(clk), .rst_n(rst_n), .func_tick(func_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .wdt_rst_o(wdt_rst_o));

    always #2 clk = ~clk;

    // Functional tick: one clock in four.
    always @(posedge clk) begin
        #1;
        tdiv = (tdiv + 1) % 4;
        func_tick = (tdiv == 0);
    end

    // ---------------- reference model ----------------
    logic [31:0] m_cnt = 0, m_load = 0, m_svc = 0;
    bit          m_run = 0, m_pre = 0, m_rst = 0, m_go = 0, m_halt = 0;
    int          m_ratio = 0, m_ps = 0;
    bit          s_pend [4];
    int          s_cnt  [4];
    logic [31:0] s_data [4];

    always @(posedge clk) begin : model
        bit ap [4];
        bit rl, st;
        if (!rst_n) begin
            m_cnt = 0; m_load = 0; m_svc = 0; m_run = 0; m_pre = 0; m_rst = 0;
            m_go = 0; m_halt = 0; m_ratio = 0; m_ps = 0;
            for (int i = 0; i < 4; i++) begin s_pend[i] = 0; s_cnt[i] = 0; s_data[i] = 0; end
        end else begin
            for (int i = 0; i < 4; i++)
                ap[i] = s_pend[i] && func_tick && s_cnt[i] == 1 && !(wr_en && wr_addr == SA[i]);
            m_rst = 0;
            rl = ap[2] && s_data[2] != m_svc;
            st = !m_pre || m_ps == (1 << m_ratio) - 1;
            if (rl) m_cnt = m_load;
            else if (m_run && func_tick && st) begin
                if (m_cnt == 32'hFFFF_FFFF) begin m_cnt = m_load; m_rst = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (rl || ap[0]) m_ps = 0;
            else if (m_run && func_tick) m_ps = st ? 0 : m_ps + 1;
            if (ap[0]) begin m_pre = s_data[0][5]; m_ratio = int'(s_data[0][4:2]); end
            if (ap[1]) m_load = s_data[1];
            if (rl) m_svc = s_data[2];
            if (ap[3]) begin
                if (m_go && s_data[3] == 32'h4444) m_run = 1;
                if (m_halt && s_data[3] == 32'h5555) m_run = 0;
                m_go   = (s_data[3] == 32'hBBBB);
                m_halt = (s_data[3] == 32'hAAAA);
            end
            for (int i = 0; i < 4; i++) begin
                if (wr_en && wr_addr == SA[i]) begin
                    s_pend[i] = 1; s_cnt[i] = 0; s_data[i] = wr_data;
                end else if (s_pend[i] && func_tick) begin
                    if (s_cnt[i] == 1) s_pend[i] = 0;
                    s_cnt[i] = (s_cnt[i] + 1) % 2;
                end
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            AREV:  return {24'h0, REV};
            ACTRL: return {26'h0, m_pre, 3'(m_ratio), 2'b00};
            ACNT:  return m_cnt;
            ALOAD: return m_load;
            ASVC:  return m_svc;
            APEND: return {27'h0, s_pend[3], s_pend[2], s_pend[1], 1'b0, s_pend[0]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] a);
        case (a)
            ACNT: return "R10"; APEND: return "R2"; ACTRL: return "R7";
            ALOAD: return "R6"; ASVC: return "R6"; AREV: return "R9";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison with the model, away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            check(req_of(rd_addr), rd_data, m_read(rd_addr));
            check("R8", {31'h0, wdt_rst_o}, {31'h0, m_rst});
            if (wdt_rst_o) hi_len++;
            else if (hi_len > 0) begin
                check("R8 width", hi_len, 1); n_pulse++; hi_len = 0;
            end
        end
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1; wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1; wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(posedge clk); #1; rd_addr = a;
        @(negedge clk); v = rd_data;
    endtask

    task automatic settle();
        logic [31:0] v;
        for (int k = 0; k < 50; k++) begin
            rd(APEND, v);
            if (v == 0) break;
        end
    endtask

    task automatic wr_settle(input logic [2:0] a, input logic [31:0] d);
        wr(a, d); settle();
    endtask

    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin @(posedge clk); if (func_tick) c++; end
    endtask

    logic [31:0] v, v0;

    initial begin
        repeat (5) @(posedge clk);
        #1; rst_n = 1; cmp_on = 1;
        // R1 reset state
        rd(ACNT, v);  check("R1 counter", v, 0);
        rd(APEND, v); check("R1 pending", v, 0);
        rd(ASVC, v);  check("R1 service", v, 0);
        check("R1 reset out", {31'h0, wdt_rst_o}, 0);
        // R9 revision
        rd(AREV, v);  check("R9 revision", v, {24'h0, REV});
        // R2 pending bits per register
        wr(ACTRL, 32'h0); rd(APEND, v); check("R2 ctrl bit0", v, 32'h01);
        settle(); rd(APEND, v); check("R2 cleared", v, 0);
        wr(ALOAD, 32'h100); rd(APEND, v); check("R2 load bit2", v, 32'h04);
        settle();
        wr(ASVC, 32'h1234); rd(APEND, v); check("R2 service bit3", v, 32'h08);
        settle();
        rd(ACNT, v); check("R6 reload", v, 32'h100);
        // R10 stopped counter holds
        wait_ticks(6); rd(ACNT, v); check("R10 stopped holds", v, 32'h100);
        // R6 repeated service word has no effect
        wr_settle(ALOAD, 32'h200);
        wr_settle(ASVC, 32'h1234);
        rd(ACNT, v); check("R6 same word ignored", v, 32'h100);
        wr_settle(ASVC, ~32'h1234);
        rd(ACNT, v); check("R6 complement reloads", v, 32'h200);
        // R5 broken start sequence
        wr(AKEY, 32'hBBBB); rd(APEND, v); check("R2 key bit4", v, 32'h10);
        settle();
        wr_settle(AKEY, 32'h1111);
        wr_settle(AKEY, 32'h4444);
        wait_ticks(5); rd(ACNT, v); check("R5 broken sequence", v, 32'h200);
        // R3 start
        wr_settle(AKEY, 32'hBBBB);
        wr_settle(AKEY, 32'h4444);
        rd(ACNT, v0); wait_ticks(5); rd(ACNT, v);
        check("R3 counts per tick", v - v0, 5);
        // R4 stop
        wr_settle(AKEY, 32'hAAAA);
        wr_settle(AKEY, 32'h5555);
        rd(ACNT, v0); wait_ticks(5); rd(ACNT, v);
        check("R4 stopped", v, v0);
        // R7 prescaler ratio 2
        wr_settle(ACTRL, (32'h1 << 5) | (32'd2 << 2));
        rd(ACTRL, v); check("R7 ctrl readback", v, 32'h28);
        wr_settle(ASVC, 32'h1234);
        wr_settle(AKEY, 32'hBBBB);
        wr_settle(AKEY, 32'h4444);
        rd(ACNT, v0); wait_ticks(8); rd(ACNT, v);
        check("R7 prescaled rate", v - v0, 2);
        // R8 rollover
        wr_settle(AKEY, 32'hAAAA);
        wr_settle(AKEY, 32'h5555);
        wr_settle(ACTRL, 32'h0);
        wr_settle(ALOAD, 32'hFFFF_FFF0);
        wr_settle(ASVC, ~32'h1234);
        wr_settle(AKEY, 32'hBBBB);
        wr_settle(AKEY, 32'h4444);
        @(posedge clk); #1; rd_addr = ACNT;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (wdt_rst_o) break;
        end
        check("R8 pulse seen", {31'h0, wdt_rst_o}, 1);
        check("R8 reload on wrap", rd_data, 32'hFFFF_FFF0);
        repeat (4) @(posedge clk);
        check("R8 pulse count", n_pulse, 1);
        repeat (4) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule